// File: doc/BRIEF.md
# Power-Mode Peripheral Clock Gating

This block decides, cycle by cycle, which peripheral clocks run and whether the processor clock runs. It holds three banks of per-peripheral enable bits: one used while the processor executes, one used in light sleep and one used in deep sleep. A small mode controller tracks the power state and selects which bank drives the enable outputs. Software enters a sleep state through a request strobe with a flag that chooses light or deep sleep, and any interrupt brings the block back to the executing state.

A read-only capability word, fixed by parameter, lists the peripherals that exist. Every write into a gating bank is masked by it, so an enable bit for an absent peripheral can never be set and always reads back as zero. The register port is a plain address/write/data interface with a registered read path.

Top module: `pwr_clk_gate`

## Requirements
- R1: After synchronous reset the mode is Run (`pwr_mode` code 0), every gating bank holds zero, `periph_en` is zero, `cpu_clk_en` is 1 and `reg_rdata` is zero.
- R2: A write with `reg_addr` 1, 2 or 3 stores `reg_wdata & CAP_MASK` into the Run, Sleep or Deep-Sleep bank respectively; reading that address returns the stored value, so bits outside `CAP_MASK` read as zero.
- R3: Address 0 reads the capability word `CAP_MASK`; writes to address 0 change nothing.
- R4: `reg_rdata` is registered: it shows, after a clock edge, the content of the address presented at that edge, taken before any write at the same edge.
- R5: In Run with no interrupt, a `sleep_req` moves the mode at the next edge to Sleep (code 1) when `sleep_deep` is 0, or to Deep-Sleep (code 2) when it is 1.
- R6: In Sleep or Deep-Sleep, `irq` high moves the mode to Run at the next edge.
- R7: A `sleep_req` presented together with `irq` high is ignored and the mode stays Run.
- R8: `periph_en` shows, one edge after the mode and banks update, the bank indexed by the mode (Run bank in Run, Sleep bank in Sleep, Deep-Sleep bank in Deep-Sleep).
- R9: `cpu_clk_en` is 1 one edge after the mode is Run and 0 one edge after it is Sleep or Deep-Sleep.
- R10: A `sleep_req` while already in a sleep mode with no interrupt leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address: 0 capability, 1 Run bank, 2 Sleep bank, 3 Deep-Sleep bank |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | NUM_PERIPH | Write data |
| reg_rdata | output | NUM_PERIPH | Registered read data |
| sleep_req | input | 1 | Request to leave Run |
| sleep_deep | input | 1 | Selects Deep-Sleep for a request |
| irq | input | 1 | Interrupt; wakes to Run and blocks sleep entry |
| pwr_mode | output | 2 | Current mode: 0 Run, 1 Sleep, 2 Deep-Sleep |
| periph_en | output | NUM_PERIPH | Registered per-peripheral clock enables |
| cpu_clk_en | output | 1 | Registered processor clock enable |

## Verification
Inputs sampled at an edge update `pwr_mode`, the banks and `reg_rdata` at that edge, while `periph_en` and `cpu_clk_en` follow one edge later. The bench drives inputs at the falling edge, advances its model across the rising edge in that same order (read and enables from the old state, then write and mode update) and compares every output at the following falling edge. Random traffic is mixed with directed cases for capability writes, masked writes, a request colliding with an interrupt and a second request while asleep.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_DEEP  = 2'd2
  } pmode_e;

  localparam int NUM_BANKS = 3;
endpackage

// File: rtl/pcg_mode_ctrl.sv
module pcg_mode_ctrl
  import pcg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sleep_req,
  input  logic   sleep_deep,
  input  logic   irq,
  output pmode_e mode
);
  pmode_e mode_nxt;

  always_comb begin
    mode_nxt = mode;
    case (mode)
      MODE_RUN:   if (sleep_req && !irq) mode_nxt = sleep_deep ? MODE_DEEP : MODE_SLEEP;
      MODE_SLEEP,
      MODE_DEEP:  if (irq) mode_nxt = MODE_RUN;
      default:    mode_nxt = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_RUN;
    else     mode <= mode_nxt;
  end

  AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && sleep_req && !irq && sleep_deep) |=> mode == MODE_DEEP); // R5
  AST_WAKE_ON_IRQ: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_RUN && irq) |=> mode == MODE_RUN); // R6
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && irq) |=> mode == MODE_RUN); // R7
  AST_NO_SLEEP_HOP: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_RUN && !irq) |=> $stable(mode)); // R10
endmodule

// File: rtl/pcg_gate_bank.sv
module pcg_gate_bank #(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] CAP  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wdata & CAP;
  end

  AST_BANK_MASKED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (q & ~CAP) == '0); // R2
endmodule

// File: rtl/pcg_en_out.sv
module pcg_en_out
  import pcg_pkg::*;
#(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] CAP   = '1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  pmode_e                            mode,
  input  logic [NUM_BANKS-1:0][WIDTH-1:0]   banks,
  output logic [WIDTH-1:0]                  periph_en,
  output logic                              cpu_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      periph_en <= '0;
      cpu_en    <= 1'b1;
    end else begin
      case (mode)
        MODE_SLEEP: periph_en <= banks[1];
        MODE_DEEP:  periph_en <= banks[2];
        default:    periph_en <= banks[0];
      endcase
      cpu_en <= (mode == MODE_RUN);
    end
  end

  AST_EN_PRESENT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (periph_en & ~CAP) == '0); // R8
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pcg_pkg::*;
#(
  parameter int                    NUM_PERIPH = 8,
  parameter logic [NUM_PERIPH-1:0] CAP_MASK   = 8'hB7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            reg_addr,
  input  logic                  reg_wr,
  input  logic [NUM_PERIPH-1:0] reg_wdata,
  output logic [NUM_PERIPH-1:0] reg_rdata,
  input  logic                  sleep_req,
  input  logic                  sleep_deep,
  input  logic                  irq,
  output logic [1:0]            pwr_mode,
  output logic [NUM_PERIPH-1:0] periph_en,
  output logic                  cpu_clk_en
);
  localparam logic [1:0] CAP_ADDR = 2'd0;

  pmode_e                                 mode;
  logic [NUM_BANKS-1:0][NUM_PERIPH-1:0]   banks;

  pcg_mode_ctrl u_mode (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .sleep_deep (sleep_deep),
    .irq        (irq),
    .mode       (mode)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pcg_gate_bank #(.WIDTH(NUM_PERIPH), .CAP(CAP_MASK)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (reg_wr && (reg_addr == 2'(b + 1))),
      .wdata (reg_wdata),
      .q     (banks[b])
    );
  end

  pcg_en_out #(.WIDTH(NUM_PERIPH), .CAP(CAP_MASK)) u_out (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .banks     (banks),
    .periph_en (periph_en),
    .cpu_en    (cpu_clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        CAP_ADDR: reg_rdata <= CAP_MASK;
        2'd1:     reg_rdata <= banks[0];
        2'd2:     reg_rdata <= banks[1];
        default:  reg_rdata <= banks[2];
      endcase
    end
  end

  assign pwr_mode = mode;

  AST_CAP_READ: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == CAP_ADDR) |=> reg_rdata == CAP_MASK); // R3
  AST_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_RUN) |=> !cpu_clk_en); // R9
  AST_CPU_RUNS: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN) |=> cpu_clk_en); // R9
endmodule

// File: tb/pwr_clk_gate_tb_top.sv
module pwr_clk_gate_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         W          = 8;
  localparam logic [W-1:0] CAP      = 8'hB7;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   reg_addr;
  logic         reg_wr;
  logic [W-1:0] reg_wdata;
  logic [W-1:0] reg_rdata;
  logic         sleep_req, sleep_deep, irq;
  logic [1:0]   pwr_mode;
  logic [W-1:0] periph_en;
  logic         cpu_clk_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_clk_gate #(.NUM_PERIPH(W), .CAP_MASK(CAP)) dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
    .sleep_deep(sleep_deep), .irq(irq), .pwr_mode(pwr_mode),
    .periph_en(periph_en), .cpu_clk_en(cpu_clk_en)
  );

  int n_chk = 0, n_fail = 0;
  logic [1:0]   m_mode;
  logic [W-1:0] m_bank [3];
  logic [W-1:0] m_en, m_rd;
  logic         m_cpu;
  string        mode_tag, rd_tag;

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(mode_tag, "pwr_mode", W'(pwr_mode), W'(m_mode));
    check("R8", "periph_en", periph_en, m_en);
    check("R9", "cpu_clk_en", W'(cpu_clk_en), W'(m_cpu));
    check(rd_tag, "reg_rdata", reg_rdata, m_rd);
  endtask

  function automatic logic [1:0] next_mode(logic [1:0] m, logic rq, logic dp, logic ir);
    if (m == 2'd0) return (rq && !ir) ? (dp ? 2'd2 : 2'd1) : 2'd0;
    return ir ? 2'd0 : m;
  endfunction

  // called just after a falling edge; returns just after the next falling edge
  task automatic cycle(logic [1:0] a, logic wr, logic [W-1:0] wd,
                       logic rq, logic dp, logic ir);
    reg_addr = a; reg_wr = wr; reg_wdata = wd;
    sleep_req = rq; sleep_deep = dp; irq = ir;
    m_en  = m_bank[m_mode];
    m_cpu = (m_mode == 2'd0);
    m_rd  = (a == 2'd0) ? CAP : m_bank[a - 2'd1];
    rd_tag = (a == 2'd0) ? "R3" : "R4";
    if (wr && a != 2'd0) m_bank[a - 2'd1] = wd & CAP;
    if (m_mode == 2'd0) mode_tag = (rq && ir) ? "R7" : "R5";
    else mode_tag = ir ? "R6" : "R10";
    m_mode = next_mode(m_mode, rq, dp, ir);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst = 1'b1; reg_addr = '0; reg_wr = 0; reg_wdata = '0;
    sleep_req = 0; sleep_deep = 0; irq = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "pwr_mode", W'(pwr_mode), '0);
    check("R1", "periph_en", periph_en, '0);
    check("R1", "cpu_clk_en", W'(cpu_clk_en), W'(1));
    check("R1", "reg_rdata", reg_rdata, '0);
    m_mode = 2'd0; m_bank[0] = '0; m_bank[1] = '0; m_bank[2] = '0;

    // R3: capability write ignored, read returns CAP
    cycle(2'd0, 1, 8'hFF, 0, 0, 0);
    cycle(2'd0, 0, 8'h00, 0, 0, 0);
    check("R3", "cap after write", reg_rdata, CAP);
    // R2: masked write into Run bank, readback masked
    cycle(2'd1, 1, 8'hFF, 0, 0, 0);
    cycle(2'd1, 0, 8'h00, 0, 0, 0);
    check("R2", "run bank readback", reg_rdata, CAP);
    cycle(2'd2, 1, 8'h48, 0, 0, 0);  // Sleep bank: only absent bits set
    cycle(2'd2, 0, 8'h00, 0, 0, 0);
    check("R2", "sleep bank masked", reg_rdata, 8'h00);
    cycle(2'd3, 1, 8'h35, 0, 0, 0);
    cycle(2'd2, 1, 8'h05, 0, 0, 0);
    // R7: request with interrupt stays Run
    cycle(2'd0, 0, 8'h00, 1, 1, 1);
    check("R7", "mode after blocked req", W'(pwr_mode), '0);
    // R5 then R10: enter Sleep, second deep request ignored
    cycle(2'd0, 0, 8'h00, 1, 0, 0);
    check("R5", "entered sleep", W'(pwr_mode), W'(1));
    cycle(2'd0, 0, 8'h00, 1, 1, 0);
    check("R10", "stay sleep", W'(pwr_mode), W'(1));
    check("R9", "cpu off in sleep", W'(cpu_clk_en), '0);
    check("R8", "sleep bank enables", periph_en, 8'h05);
    // R6: wake
    cycle(2'd0, 0, 8'h00, 0, 0, 1);
    check("R6", "woke to run", W'(pwr_mode), '0);
    cycle(2'd0, 0, 8'h00, 1, 1, 0);
    check("R5", "entered deep", W'(pwr_mode), W'(2));
    cycle(2'd0, 0, 8'h00, 0, 0, 0);
    check("R8", "deep bank enables", periph_en, 8'h35);
    cycle(2'd0, 0, 8'h00, 0, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      cycle(2'($urandom), ($urandom % 3) == 0, W'($urandom),
            ($urandom % 6) == 0, 1'($urandom), ($urandom % 8) == 0);
    end
    finish_run();
  end
endmodule